// File: doc/BRIEF.md
# Truncating K-Tile Float Accumulator

This block sums a stream of 32-bit single-precision partial results that all belong to one output element of a tiled matrix product, one partial per step along the shared K dimension. Before each partial is added, its raw bit pattern can lose a programmable number of low-order bits. The bits are either simply cleared or rounded first by adding half of the dropped weight. This lets a reduced-width tile accumulator be modelled, or its effect measured, while the running sum itself stays at full single precision.

A run begins with a start pulse that clears the sum to +0. Each accepted word is reduced and then added with round-to-nearest-even. The word flagged as last ends the run, and one cycle later the final sum appears with a one-cycle valid strobe. Setting the drop count to zero passes every partial through untouched, which gives the exact reference result.

Top module: `ktacc_top`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0x00000000.
- R2: With round_en at 0, a partial has its lowest trunc_bits bit-pattern bits forced to zero before it is added.
- R3: With round_en at 1 and trunc_bits N > 0, the value 1<<(N-1) is added to the raw 32-bit pattern as an unsigned integer, and then the low N bits are cleared. A carry may ripple into the exponent field.
- R4: When trunc_bits is 0, each partial enters the sum unchanged, whatever round_en is.
- R5: trunc_bits values above 23 behave exactly like 23.
- R6: Partials are added into a single-precision running sum (sign bit 31, exponent bits 30:23 with bias 127, fraction bits 22:0) with round-to-nearest, ties-to-even.
- R7: An accepted word with in_last set makes out_valid high for exactly one cycle, on the cycle after that word, with out_data holding the final sum.
- R8: A start pulse clears the running sum to +0 and begins a new run. This holds in any state, including in the middle of a run.
- R9: Outside a run (after reset or after the result cycle, until start), in_valid and in_last have no effect. No out_valid is produced and out_data keeps its value.
- R10: Operands with a zero exponent field count as zero, and a sum whose magnitude falls below the smallest normal becomes a zero carrying the sign of the exact result.
- R11: Adding two equal magnitudes of opposite sign gives +0 (0x00000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the sum and opens a run |
| in_valid | input | 1 | Partial word present |
| in_last | input | 1 | Marks the final partial of a run |
| in_data | input | 32 | Partial result, single-precision bit pattern |
| trunc_bits | input | 5 | Number of low bits to drop (saturates at 23) |
| round_en | input | 1 | Adds half of the dropped weight before clearing |
| out_valid | output | 1 | One-cycle strobe for the final sum |
| out_data | output | 32 | Running or final sum |

## Verification
Single-tile runs that add a partial to zero expose the reduced word exactly. These runs separate plain clearing from rounding, show a round carry reaching the exponent, and show that a count of 31 acts as 23 rather than wiping the whole word. Two-tile runs exercise the adder with a tie that stays on an even result, a tie that rounds up, an exact sum one unit above a power of two, cancellation to +0, an exponent carry, a denormal operand and a sub-normal result. The same pair of inputs is run with and without dropping bits, so the reference mode can be compared with the truncating mode. Directed runs cover a four-tile stream, a restart in the middle of a run, words offered outside a run, and the width of the result strobe.

// File: rtl/ktacc_pkg.sv
package ktacc_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int FRC_W = 23;
  localparam int NT_W  = 5;
  localparam int NT_MAX = FRC_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_DONE  = 2'd2
  } acc_state_e;

  // position of the highest set bit in a 28-bit word
  function automatic logic [4:0] lead_one(input logic [27:0] v);
    lead_one = '0;
    for (int i = 0; i < 28; i++) begin
      if (v[i]) lead_one = 5'(i);
    end
  endfunction
endpackage

// File: rtl/ktacc_trunc.sv
module ktacc_trunc
  import ktacc_pkg::*;
(
  input  logic [FP_W-1:0] word_i,
  input  logic [NT_W-1:0] nbits_i,
  input  logic            round_en_i,
  output logic [FP_W-1:0] word_o
);
  logic [NT_W-1:0] n_eff;
  logic [FP_W-1:0] keep_mask;
  logic [FP_W-1:0] half_lsb;

  always_comb begin
    n_eff     = (nbits_i > NT_W'(NT_MAX)) ? NT_W'(NT_MAX) : nbits_i;
    keep_mask = ~((FP_W'(1) << n_eff) - FP_W'(1));
    half_lsb  = (round_en_i && (n_eff != '0)) ? (FP_W'(1) << (n_eff - NT_W'(1))) : '0;
    word_o    = (word_i + half_lsb) & keep_mask;
  end
endmodule

// File: rtl/ktacc_fpadd.sv
module ktacc_fpadd
  import ktacc_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic [FP_W-1:0] sum_o
);
  localparam int MW  = FRC_W + 1;  // significand with hidden bit
  localparam int XW  = MW + 3;     // plus guard, round, sticky
  localparam int SW  = XW + 1;     // plus carry
  localparam int EW2 = EXP_W + 3;  // signed working exponent

  logic             a_zero, b_zero, a_big;
  logic [FP_W-2:0]  mag_a, mag_b;
  logic             big_s, sml_s;
  logic [EXP_W-1:0] big_e, sml_e, e_diff;
  logic [MW-1:0]    big_m, sml_m;
  logic [4:0]       shamt, msb, lz;
  logic [2*XW-1:0]  wide;
  logic [XW-1:0]    big_x, sml_x, norm;
  logic [SW-1:0]    raw;
  logic signed [EW2-1:0] e_w;
  logic             rnd_up;
  logic [MW:0]      mant_r;
  logic [FRC_W-1:0] frac;

  always_comb begin
    a_zero = (a_i[FP_W-2 -: EXP_W] == '0);
    b_zero = (b_i[FP_W-2 -: EXP_W] == '0);
    mag_a  = a_zero ? '0 : a_i[FP_W-2:0];
    mag_b  = b_zero ? '0 : b_i[FP_W-2:0];
    a_big  = (mag_a >= mag_b);

    big_s = a_big ? a_i[FP_W-1] : b_i[FP_W-1];
    sml_s = a_big ? b_i[FP_W-1] : a_i[FP_W-1];
    big_e = a_big ? mag_a[FP_W-2 -: EXP_W] : mag_b[FP_W-2 -: EXP_W];
    sml_e = a_big ? mag_b[FP_W-2 -: EXP_W] : mag_a[FP_W-2 -: EXP_W];
    big_m = (big_e == '0) ? '0 : {1'b1, (a_big ? mag_a[FRC_W-1:0] : mag_b[FRC_W-1:0])};
    sml_m = (sml_e == '0) ? '0 : {1'b1, (a_big ? mag_b[FRC_W-1:0] : mag_a[FRC_W-1:0])};

    // alignment of the smaller operand, lost bits folded into sticky
    e_diff = big_e - sml_e;
    shamt  = (e_diff > EXP_W'(XW)) ? 5'(XW) : e_diff[4:0];
    big_x  = {big_m, 3'b000};
    wide   = {sml_m, 3'b000, {XW{1'b0}}} >> shamt;
    sml_x  = wide[2*XW-1:XW];
    sml_x[0] = sml_x[0] | (|wide[XW-1:0]);

    raw = (big_s == sml_s) ? ({1'b0, big_x} + {1'b0, sml_x})
                           : ({1'b0, big_x} - {1'b0, sml_x});

    msb  = lead_one(raw);
    lz   = '0;
    norm = '0;
    e_w  = $signed({3'b000, big_e});
    if (raw[SW-1]) begin
      norm = {raw[SW-1:2], raw[1] | raw[0]};
      e_w  = e_w + EW2'(1);
    end else begin
      lz   = 5'(XW - 1) - msb;
      norm = raw[XW-1:0] << lz;
      e_w  = e_w - $signed({6'b0, lz});
    end

    // round to nearest, ties to even
    rnd_up = norm[2] & (norm[1] | norm[0] | norm[3]);
    mant_r = {1'b0, norm[XW-1:3]} + (MW+1)'(rnd_up);
    frac   = mant_r[FRC_W-1:0];
    if (mant_r[MW]) begin
      e_w  = e_w + EW2'(1);
      frac = mant_r[FRC_W:1];
    end

    if (raw == '0)
      sum_o = '0;
    else if (e_w <= EW2'(0))
      sum_o = {big_s, {(FP_W-1){1'b0}}};
    else if (e_w >= EW2'(255))
      sum_o = {big_s, {EXP_W{1'b1}}, {FRC_W{1'b0}}};
    else
      sum_o = {big_s, e_w[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/ktacc_top.sv
module ktacc_top
  import ktacc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic [31:0]     in_data,
  input  logic [4:0]      trunc_bits,
  input  logic            round_en,
  output logic            out_valid,
  output logic [31:0]     out_data
);
  logic          rst_meta, rst_sync_n;
  acc_state_e    state_q, state_d;
  logic [FP_W-1:0] acc_q, acc_d, tile_word, sum_word;
  logic          acc_en;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ktacc_trunc u_trunc (
    .word_i     (in_data),
    .nbits_i    (trunc_bits),
    .round_en_i (round_en),
    .word_o     (tile_word)
  );

  ktacc_fpadd u_add (
    .a_i   (acc_q),
    .b_i   (tile_word),
    .sum_o (sum_word)
  );

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    acc_en  = 1'b0;
    if (start) begin
      state_d = ST_ACCUM;
      acc_d   = '0;
      acc_en  = 1'b1;
    end else begin
      case (state_q)
        ST_ACCUM: begin
          if (in_valid) begin
            acc_d  = sum_word;
            acc_en = 1'b1;
            if (in_last) state_d = ST_DONE;
          end
        end
        ST_DONE: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  acc_q <= '0;
    else if (acc_en)  acc_q <= acc_d;
  end

  assign out_valid = (state_q == ST_DONE);
  assign out_data  = acc_q;

  // R7
  result_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(in_valid && in_last && !start && state_q == ST_ACCUM));
  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |=> !out_valid);
  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> (acc_q == '0));
  // R9
  idle_holds_sum_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_ACCUM && !start) |=> $stable(acc_q));
  // R4
  zero_drop_passthru_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trunc_bits == 5'd0) |-> (tile_word == in_data));
  // R5
  drop_saturates_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trunc_bits > 5'd23) |-> (tile_word[22:0] == 23'd0));
  // R10
  no_subnormal_sum_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sum_word[30:23] == 8'd0) |-> (sum_word[22:0] == 23'd0));
endmodule

// File: tb/ktacc_top_bench.sv
module ktacc_top_bench;
  logic        clk, rst_n, start, in_valid, in_last, round_en;
  logic [31:0] in_data;
  logic [4:0]  trunc_bits;
  logic        out_valid;
  logic [31:0] out_data;
  int          n_chk, n_fail;
  logic        finished;

  localparam int NV = 16;
  // two-tile vectors: a, b, drop count, round enable, expected sum
  localparam logic [31:0] VA [NV] = '{
    32'h3F800000, 32'h3F800001, 32'h3F800001, 32'h3F8000FF, 32'h3F8000FF, 32'h3FFFFFFF,
    32'h3FFFFFFF, 32'h3F800000, 32'h4B800000, 32'h4B800000, 32'h4B800001, 32'h40000000,
    32'h00400000, 32'h00800001, 32'h3F800001, 32'h3F800001};
  localparam logic [31:0] VB [NV] = '{
    32'h40000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000,
    32'h00000000, 32'hBF800000, 32'h3F800000, 32'h40000000, 32'h3F800000, 32'hBF800000,
    32'h3F800000, 32'h80800000, 32'h3F800001, 32'h3F800001};
  localparam logic [4:0] VN [NV] = '{
    5'd0, 5'd1, 5'd1, 5'd8, 5'd8, 5'd23, 5'd31, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd1};
  localparam logic VR [NV] = '{
    1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] VE [NV] = '{
    32'h40400000,  // R6 exact 1+2
    32'h3F800000,  // R2 clear one bit
    32'h3F800002,  // R3 round then clear
    32'h3F800100,  // R3 eight bits rounded up
    32'h3F800000,  // R2 eight bits cleared
    32'h40000000,  // R3 round carry into exponent
    32'h3F800000,  // R5 count 31 acts as 23
    32'h00000000,  // R11 cancellation
    32'h4B800000,  // R6 tie kept even
    32'h4B800001,  // R6 exact
    32'h4B800002,  // R6 tie rounded up to even
    32'h3F800000,  // R6 subtraction renormalizes
    32'h3F800000,  // R10 denormal operand is zero
    32'h00000000,  // R10 tiny result flushed
    32'h40000001,  // R4 reference mode
    32'h40000000}; // R2 same inputs truncated
  localparam int VQ [NV] = '{6, 2, 3, 3, 2, 3, 5, 11, 6, 6, 6, 6, 10, 10, 4, 2};

  ktacc_top u_ktacc_top (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .trunc_bits(trunc_bits), .round_en(round_en),
    .out_valid(out_valid), .out_data(out_data));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic begin_run();
    @(negedge clk); start = 1'b1; in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic last);
    in_valid = 1'b1; in_data = d; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    start = 0; in_valid = 0; in_last = 0; in_data = '0; trunc_bits = '0; round_en = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, {31'b0, out_valid}, 32'd0);  // R1
    check(1, out_data, 32'h0);            // R1

    for (int i = 0; i < NV; i++) begin
      trunc_bits = VN[i]; round_en = VR[i];
      begin_run();
      push(VA[i], 1'b0);
      push(VB[i], 1'b1);
      check(7, {31'b0, out_valid}, 32'd1);  // R7 strobe after last
      check(VQ[i], out_data, VE[i]);
      @(negedge clk);
      check(7, {31'b0, out_valid}, 32'd0);  // R7 one cycle only
    end

    // R9: words offered outside a run change nothing
    trunc_bits = 0; round_en = 0;
    push(32'h40800000, 1'b1);
    check(9, {31'b0, out_valid}, 32'd0);
    push(32'h40800000, 1'b1);
    check(9, {31'b0, out_valid}, 32'd0);
    check(9, out_data, 32'h40000000);

    // R6: four-tile stream 1+1+1+1
    begin_run();
    push(32'h3F800000, 1'b0);
    push(32'h3F800000, 1'b0);
    push(32'h3F800000, 1'b0);
    check(7, {31'b0, out_valid}, 32'd0);
    push(32'h3F800000, 1'b1);
    check(6, out_data, 32'h40800000);
    check(7, {31'b0, out_valid}, 32'd1);

    // R8: restart in the middle of a run
    begin_run();
    push(32'h41000000, 1'b0);
    check(8, out_data, 32'h41000000);
    begin_run();
    check(8, out_data, 32'h00000000);
    push(32'h3F800000, 1'b1);
    check(8, out_data, 32'h3F800000);
    check(7, {31'b0, out_valid}, 32'd1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule